// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a small universal shift register. Two select inputs choose, on each rising clock edge, whether the register holds its value, shifts toward its high end, shifts toward its low end, or loads a full word. Parallel data enters and leaves through one shared bidirectional port. For synthesis the port is split into an input bus, an output bus and an output-enable flag, and the enable drives the physical tri-state pad outside this block.

Each shift direction has its own serial input. The two end bits are brought out on dedicated serial outputs that are never disabled, so several of these registers can be chained whatever state their parallel ports are in. An active-low asynchronous clear empties the register at once. Two active-low output controls gate only the port driver and never the register itself. During a parallel load the driver turns itself off, so that the port can act as an input.

Top module: `bidir_shift_reg`

## Requirements
- R1: With `mode_sel` = 2'b00, a rising clock edge leaves the register, `port_out` and both end outputs unchanged.
- R2: With `mode_sel` = 2'b01, a rising edge moves `ser_right_in` into bit 0, and each bit i above 0 takes the previous value of bit i-1.
- R3: With `mode_sel` = 2'b10, a rising edge moves `ser_left_in` into bit WIDTH-1, and each bit i below WIDTH-1 takes the previous value of bit i+1.
- R4: With `mode_sel` = 2'b11, a rising edge copies `port_in` into the register, bit for bit.
- R5: `port_oe` is high only when `oe1_n` and `oe2_n` are both low and `mode_sel` is not 2'b11. Otherwise it is low.
- R6: The level of `oe1_n` and `oe2_n` has no effect on holding, shifting or loading. `port_out` and the end outputs show the register contents even while `port_oe` is low.
- R7: When `clr_n` goes low, every register bit, `port_out` and both end outputs go to 0 without waiting for a clock edge.
- R8: `end_lo_out` always equals register bit 0 and `end_hi_out` always equals bit WIDTH-1, whatever the output controls are doing.
- R9: While `clr_n` is low, clock edges leave the register at 0 in every mode. The first rising edge after `clr_n` returns high carries out the selected mode.
- R10: `port_out` bit 0 is the first register stage (the end fed by `ser_right_in`), and `port_out` bit WIDTH-1 is the last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_right_in | input | 1 | Serial input entering bit 0 during an up shift |
| ser_left_in | input | 1 | Serial input entering bit WIDTH-1 during a down shift |
| oe1_n | input | 1 | Port output control 1, active low |
| oe2_n | input | 1 | Port output control 2, active low |
| port_in | input | WIDTH | Input side of the shared parallel port |
| port_out | output | WIDTH | Output side of the shared parallel port (register contents) |
| port_oe | output | 1 | Drive enable for the shared port pad |
| end_lo_out | output | 1 | Serial output carrying bit 0 |
| end_hi_out | output | 1 | Serial output carrying bit WIDTH-1 |

## Verification
The clocked properties assume that `mode_sel`, the serial inputs and `port_in` are stable around each rising edge, and that `clr_n` is released well away from an edge. The stimulus changes every input on the falling edge. It moves `clr_n` only in the low half of the clock period. The shift and load properties are switched off while the clear is active, because an asynchronous clear may override the expected next value between two edges. The sweep steps through every mode, output-control pair and serial-input pair together, so that each property is exercised with the port both enabled and disabled.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHUP  = 2'b01,
        MODE_SHDN  = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    typedef struct packed {
        logic hold;
        logic shift_up;
        logic shift_dn;
        logic load;
    } op_t;

    function automatic op_t decode_op(input logic [1:0] sel);
        op_t o;
        o = '0;
        case (mode_e'(sel))
            MODE_HOLD: o.hold     = 1'b1;
            MODE_SHUP: o.shift_up = 1'b1;
            MODE_SHDN: o.shift_dn = 1'b1;
            default:   o.load     = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/shr_mode_decode.sv
module shr_mode_decode
    import shr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output op_t        op
);
    always_comb begin
        op = decode_op(mode_sel);
    end
endmodule

// File: rtl/shr_reg_core.sv
module shr_reg_core
    import shr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  op_t              op,
    input  logic             ser_up,
    input  logic             ser_dn,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lo_end
            assign from_lo = ser_up;
        end else begin : g_lo_mid
            assign from_lo = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign from_hi = ser_dn;
        end else begin : g_hi_mid
            assign from_hi = q[i+1];
        end

        always_comb begin
            if (op.hold)          d[i] = q[i];
            else if (op.shift_up) d[i] = from_lo;
            else if (op.shift_dn) d[i] = from_hi;
            else if (op.load)     d[i] = par_in[i];
            else                  d[i] = q[i];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/shr_port_ctrl.sv
module shr_port_ctrl (
    input  logic oe1_n,
    input  logic oe2_n,
    input  logic loading,
    output logic drive
);
    logic ctrl_ok;
    always_comb begin
        ctrl_ok = ~(oe1_n | oe2_n);
        drive   = ctrl_ok & ~loading;
    end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import shr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic             port_oe,
    output logic             end_lo_out,
    output logic             end_hi_out
);
    localparam int TOP = WIDTH - 1;

    op_t              op;
    logic [WIDTH-1:0] q;

    shr_mode_decode u_dec (
        .mode_sel (mode_sel),
        .op       (op)
    );

    shr_reg_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .op     (op),
        .ser_up (ser_right_in),
        .ser_dn (ser_left_in),
        .par_in (port_in),
        .q      (q)
    );

    shr_port_ctrl u_port (
        .oe1_n   (oe1_n),
        .oe2_n   (oe2_n),
        .loading (op.load),
        .drive   (port_oe)
    );

    assign port_out   = q;
    assign end_lo_out = q[0];
    assign end_hi_out = q[TOP];
endmodule

// File: rtl/shr_chk.sv
module shr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode_sel,
    input logic             ser_right_in,
    input logic             ser_left_in,
    input logic             oe1_n,
    input logic             oe2_n,
    input logic [WIDTH-1:0] port_in,
    input logic [WIDTH-1:0] port_out,
    input logic             port_oe,
    input logic             end_lo_out,
    input logic             end_hi_out
);
    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b00 |=> $stable(port_out));

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b01 |=> port_out == {$past(port_out[WIDTH-2:0]), $past(ser_right_in)});

    // R3
    shift_dn_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b10 |=> port_out == {$past(ser_left_in), $past(port_out[WIDTH-1:1])});

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |=> port_out == $past(port_in));

    // R5
    load_port_off_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |-> !port_oe);

    // R5
    ctrl_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (oe1_n || oe2_n) |-> !port_oe);

    // R8
    end_lo_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b01 |=> end_lo_out == $past(ser_right_in));

    // R8
    end_hi_follow_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b10 |=> end_hi_out == $past(ser_left_in));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (port_out == '0 && !end_lo_out && !end_hi_out));
endmodule

bind bidir_shift_reg shr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk          (clk),
    .clr_n        (clr_n),
    .mode_sel     (mode_sel),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .oe1_n        (oe1_n),
    .oe2_n        (oe2_n),
    .port_in      (port_in),
    .port_out     (port_out),
    .port_oe      (port_oe),
    .end_lo_out   (end_lo_out),
    .end_hi_out   (end_hi_out)
);

// File: tb/bidir_shift_reg_tb_top.sv
module bidir_shift_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   mode_sel;
    logic         ser_right_in, ser_left_in, oe1_n, oe2_n;
    logic [W-1:0] port_in, port_out;
    logic         port_oe, end_lo_out, end_hi_out;

    int           n_chk  = 0;
    int           n_fail = 0;
    logic [W-1:0] model  = '0;

    always #10 clk = ~clk;

    bidir_shift_reg #(.WIDTH(W)) dut_i (
        .clk (clk), .clr_n (clr_n), .mode_sel (mode_sel),
        .ser_right_in (ser_right_in), .ser_left_in (ser_left_in),
        .oe1_n (oe1_n), .oe2_n (oe2_n), .port_in (port_in),
        .port_out (port_out), .port_oe (port_oe),
        .end_lo_out (end_lo_out), .end_hi_out (end_hi_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(req, port_out, model);
        check({req, "/R8 low end"},  {{(W-1){1'b0}}, end_lo_out}, {{(W-1){1'b0}}, model[0]});
        check({req, "/R8 high end"}, {{(W-1){1'b0}}, end_hi_out}, {{(W-1){1'b0}}, model[W-1]});
    endtask

    task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                        input logic [W-1:0] pin, input logic o1, input logic o2);
        string tag;
        logic  exp_oe;
        @(negedge clk);
        mode_sel = m; ser_right_in = sr; ser_left_in = sl;
        port_in = pin; oe1_n = o1; oe2_n = o2;
        #1;
        exp_oe = !o1 && !o2 && (m != 2'b11);
        check("R5 port enable", {{(W-1){1'b0}}, port_oe}, {{(W-1){1'b0}}, exp_oe});
        @(posedge clk);
        case (m)
            2'b00: begin model = model;                   tag = "R1 hold"; end
            2'b01: begin model = {model[W-2:0], sr};      tag = "R2 shift up"; end
            2'b10: begin model = {sl, model[W-1:1]};      tag = "R3 shift down"; end
            default: begin model = pin;                   tag = "R4 load"; end
        endcase
        if (o1 || o2) tag = {tag, " R6 port off"};
        #2;
        check_all(tag);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr_n = 1'b0; mode_sel = 2'b00; ser_right_in = 1'b0; ser_left_in = 1'b0;
        oe1_n = 1'b1; oe2_n = 1'b1; port_in = '0;
        #1;
        check_all("R7 reset state");
        repeat (2) @(posedge clk);
        @(negedge clk); #3 clr_n = 1'b1;

        // R10: bit 0 of the port is the low serial end
        step(2'b11, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0);
        check("R10 port bit0", {{(W-1){1'b0}}, port_out[0]}, {{(W-1){1'b0}}, 1'b1});
        check("R10 low end",   {{(W-1){1'b0}}, end_lo_out},  {{(W-1){1'b0}}, 1'b1});
        step(2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R10 port bit1", {{(W-1){1'b0}}, port_out[1]}, {{(W-1){1'b0}}, 1'b1});

        // sweep over modes, output controls and serial inputs
        for (int k = 0; k < 1024; k++) begin
            logic [W-1:0] pat;
            pat = W'((k * 37 + (k >> 3) * 91) ^ 8'h5A);
            step(k[1:0], k[4], k[5], pat, k[2], k[3]);
        end

        // R7: asynchronous clear with no clock edge in between
        step(2'b11, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0);
        @(negedge clk); #3 clr_n = 1'b0; #1;
        model = '0;
        check_all("R7 async clear");

        // R9: clock edges while clear is held low do nothing
        mode_sel = 2'b11; port_in = 8'hA5; oe1_n = 1'b0; oe2_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check_all("R9 clear priority");
        @(negedge clk); #3 clr_n = 1'b1;
        @(posedge clk); #2;
        model = 8'hA5;
        check_all("R9 first edge after clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule